// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recently used virtual-to-physical page mappings so that most memory accesses skip the page table walk. A requester presents a 20-bit virtual page number and an access kind. The block then reports, in the same cycle, one of three results: a hit with the physical page number, a miss, or a protection fault. A miss tells the page table walker to fetch the mapping. The walker then writes the tag, page number and permission and dirty bits back through the fill port.

Any slot can hold any mapping. When a new mapping arrives it goes to a free slot, and only when none is free does it displace the slot used least recently. Two coherence controls keep the contents in step with memory. A flush empties every slot, for use when the page table base changes on a context switch. An invalidate drops the single slot that matches a given virtual page number after its table entry has been edited.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is empty, so any lookup misses. With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all 0.
- R2: A lookup whose page matches a valid slot with the needed permission asserts `lk_hit` in the same cycle, and `lk_ppn` carries that slot's physical page. The access code sets the permission needed: 2'b00 needs read, 2'b01 needs write, 2'b10 needs execute, and 2'b11 is treated like read.
- R3: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is asserted.
- R4: A lookup that matches a valid slot lacking the needed permission asserts `lk_fault` and does not refresh that slot's recency.
- R5: A permitted write lookup that matches a slot whose dirty bit is 0 reports `lk_miss`.
- R6: A fill whose page already sits in a valid slot overwrites that slot, so no page is ever held twice.
- R7: A fill of a page that is not present goes to the lowest-numbered empty slot. The fill bits are {read, write, execute, dirty}, and the slot becomes valid on the next edge.
- R8: When no slot is empty, a fill replaces the slot used least recently. Only hits and fills refresh recency. After reset, higher-numbered slots count as older.
- R9: `flush` empties every slot at the next edge.
- R10: `inv_valid` empties only the slot that holds `inv_vpn`. A page that is not present leaves every slot as it was.
- R11: Controls rank flush, then invalidate, then fill. A lower-ranked request in the same cycle is dropped. A hit refreshes recency only in a cycle with none of the three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_acc | input | 2 | Access kind (00 read, 01 write, 10 execute, 11 read) |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | Walk needed |
| lk_fault | output | 1 | Permission refused |
| lk_ppn | output | PPN_W | Physical page of the matching slot, 0 if none |
| fill_valid | input | 1 | Write a mapping |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| fill_ex | input | 1 | Execute allowed |
| fill_dirty | input | 1 | Page already dirty |
| flush | input | 1 | Empty all slots |
| inv_valid | input | 1 | Empty one slot |
| inv_vpn | input | VPN_W | Page to drop |

## Verification
The checker enforces four rules on every cycle: at most one lookup outcome, an outcome exactly when a lookup is presented, a flush leaving no valid slot, and the valid count rising by no more than one per edge and never without a fill. Other behaviour appears only in the bench's scenarios. Eviction order, the choice of slot on a fill, the write-to-clean miss and the ranking of the controls all fall in this group. The bench's reference model, built on timestamps, follows them through directed and random traffic.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic dirty;
    } perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][VPN_W-1:0] tags_i,
    input  logic [VPN_W-1:0]        key_i,
    output logic                    any_o,
    output logic [IDX_W-1:0]        idx_o
);
    logic [N-1:0] hit_vec;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = valid_i[i] && (tags_i[i] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |hit_vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][IDX_W-1:0] age_i,
    input  logic                    same_any_i,
    input  logic [IDX_W-1:0]        same_idx_i,
    output logic [IDX_W-1:0]        idx_o
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (age_i[i] == OLDEST) old_idx = IDX_W'(i);
        end
    end

    assign idx_o = same_any_i ? same_idx_i : (free_any ? free_idx : old_idx);
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0][IDX_W-1:0] age_i,
    input  logic                    touch_en_i,
    input  logic [IDX_W-1:0]        touch_idx_i,
    output logic [N-1:0][IDX_W-1:0] age_o
);
    logic [IDX_W-1:0] ref_age;
    assign ref_age = age_i[touch_idx_i];

    for (genvar i = 0; i < N; i++) begin : g_age
        always_comb begin
            age_o[i] = age_i[i];
            if (touch_en_i) begin
                if (touch_idx_i == IDX_W'(i))  age_o[i] = '0;
                else if (age_i[i] < ref_age)   age_o[i] = age_i[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_ex,
    input  logic             fill_dirty,
    input  logic             flush,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn
);
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0][VPN_W-1:0] vpn;
        logic [N-1:0][PPN_W-1:0] ppn;
        perm_t [N-1:0]           perm;
        logic [N-1:0][IDX_W-1:0] age;
    } state_t;

    state_t state_q, state_d;
    logic [N-1:0] valid_vec;
    assign valid_vec = state_q.valid;

    // Associative searches: lookup, invalidate and fill keys
    logic             lk_any, inv_any, fill_any;
    logic [IDX_W-1:0] lk_idx, inv_idx, fill_idx, vic_idx;

    tlb_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
        .valid_i(state_q.valid), .tags_i(state_q.vpn), .key_i(lk_vpn),
        .any_o(lk_any), .idx_o(lk_idx)
    );
    tlb_match #(.N(N), .VPN_W(VPN_W)) u_inv_match (
        .valid_i(state_q.valid), .tags_i(state_q.vpn), .key_i(inv_vpn),
        .any_o(inv_any), .idx_o(inv_idx)
    );
    tlb_match #(.N(N), .VPN_W(VPN_W)) u_fill_match (
        .valid_i(state_q.valid), .tags_i(state_q.vpn), .key_i(fill_vpn),
        .any_o(fill_any), .idx_o(fill_idx)
    );

    tlb_victim #(.N(N)) u_victim (
        .valid_i(state_q.valid), .age_i(state_q.age),
        .same_any_i(fill_any), .same_idx_i(fill_idx), .idx_o(vic_idx)
    );

    // Permission evaluation for the matching slot
    acc_e  acc;
    perm_t lk_perm;
    logic  perm_ok, need_clean;
    assign acc     = acc_e'(lk_acc);
    assign lk_perm = state_q.perm[lk_idx];

    always_comb begin
        unique case (acc)
            ACC_WRITE: perm_ok = lk_perm.wr;
            ACC_EXEC:  perm_ok = lk_perm.ex;
            default:   perm_ok = lk_perm.rd;
        endcase
    end

    assign need_clean = (acc == ACC_WRITE) && !lk_perm.dirty;
    assign lk_fault   = lk_valid && lk_any && !perm_ok;
    assign lk_hit     = lk_valid && lk_any && perm_ok && !need_clean;
    assign lk_miss    = lk_valid && !lk_hit && !lk_fault;
    assign lk_ppn     = lk_any ? state_q.ppn[lk_idx] : '0;

    // Control ranking: flush, invalidate, fill, then hit refresh
    logic do_inv, do_fill, do_refresh, touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic [N-1:0][IDX_W-1:0] age_nx;

    assign do_inv     = !flush && inv_valid && inv_any;
    assign do_fill    = !flush && !inv_valid && fill_valid;
    assign do_refresh = !flush && !inv_valid && !fill_valid && lk_hit;
    assign touch_en   = do_fill || do_refresh;
    assign touch_idx  = do_fill ? vic_idx : lk_idx;

    tlb_lru #(.N(N)) u_lru (
        .age_i(state_q.age), .touch_en_i(touch_en),
        .touch_idx_i(touch_idx), .age_o(age_nx)
    );

    always_comb begin
        state_d     = state_q;
        state_d.age = age_nx;
        if (flush) begin
            state_d.valid = '0;
        end else if (do_inv) begin
            state_d.valid[inv_idx] = 1'b0;
        end else if (do_fill) begin
            state_d.valid[vic_idx] = 1'b1;
            state_d.vpn[vic_idx]   = fill_vpn;
            state_d.ppn[vic_idx]   = fill_ppn;
            state_d.perm[vic_idx]  = '{rd: fill_rd, wr: fill_wr, ex: fill_ex, dirty: fill_dirty};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.valid <= '0;
            state_q.vpn   <= '0;
            state_q.ppn   <= '0;
            state_q.perm  <= '0;
            for (int i = 0; i < N; i++) state_q.age[i] <= IDX_W'(i);
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_valid,
    input logic         lk_hit,
    input logic         lk_miss,
    input logic         lk_fault,
    input logic         fill_valid,
    input logic         flush,
    input logic [N-1:0] valid_vec
);
    // R3
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    // R3
    lookup_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit || lk_miss || lk_fault));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    // R7
    fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> ($countones(valid_vec) <= $countones($past(valid_vec)) + 1));

    // R10
    no_fill_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> ($countones(valid_vec) <= $countones($past(valid_vec))));
endmodule

bind tlb_fa tlb_fa_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_fault(lk_fault), .fill_valid(fill_valid),
    .flush(flush), .valid_vec(valid_vec)
);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
    localparam int N = 16;
    localparam int VW = 20;
    localparam int PW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, fill_valid = 0, flush = 0, inv_valid = 0;
    logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
    logic [1:0] lk_acc = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic fill_rd = 0, fill_wr = 0, fill_ex = 0, fill_dirty = 0;
    logic lk_hit, lk_miss, lk_fault;
    logic [PW-1:0] lk_ppn;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model
    bit mv[N];
    int mvpn[N];
    int mppn[N];
    bit [3:0] mperm[N];   // {rd, wr, ex, dirty}
    longint stamp[N];
    longint now = 0;

    always #4 clk = ~clk;

    tlb_fa #(.N(N), .VPN_W(VW), .PPN_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_ppn(lk_ppn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_dirty(fill_dirty),
        .flush(flush), .inv_valid(inv_valid), .inv_vpn(inv_vpn)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mvpn[i] = 0; mppn[i] = 0; mperm[i] = 0;
            stamp[i] = -i;
        end
        now = 0;
    endtask

    function automatic int find(input int vpn);
        for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) return i;
        return -1;
    endfunction

    task automatic cycle(input bit lv, input int vpn, input int acc,
                         input bit fv, input int fvpn, input int fppn, input bit [3:0] fp,
                         input bit fl, input bit iv, input int ivpn, input string tag);
        int j, slot;
        bit need, eh, em, ef;
        longint best;
        @(negedge clk);
        lk_valid = lv; lk_vpn = VW'(vpn); lk_acc = 2'(acc);
        fill_valid = fv; fill_vpn = VW'(fvpn); fill_ppn = PW'(fppn);
        {fill_rd, fill_wr, fill_ex, fill_dirty} = fp;
        flush = fl; inv_valid = iv; inv_vpn = VW'(ivpn);
        #1;
        j = find(vpn);
        eh = 0; em = 0; ef = 0;
        if (lv) begin
            if (j < 0) em = 1;
            else begin
                need = (acc == 1) ? mperm[j][2] : (acc == 2) ? mperm[j][1] : mperm[j][3];
                if (!need) ef = 1;
                else if (acc == 1 && !mperm[j][0]) em = 1;
                else eh = 1;
            end
        end
        checks++;
        if ({lk_hit, lk_miss, lk_fault} !== {eh, em, ef}) begin
            failures++;
            $display("FAIL %s vpn=%0d acc=%0d hit/miss/fault actual=%b%b%b expected=%b%b%b",
                     tag, vpn, acc, lk_hit, lk_miss, lk_fault, eh, em, ef);
        end
        if (eh) begin
            checks++;
            if (lk_ppn !== PW'(mppn[j])) begin
                failures++;
                $display("FAIL %s ppn actual=%0h expected=%0h", tag, lk_ppn, mppn[j]);
            end
        end
        @(posedge clk);
        now++;
        if (fl) begin
            for (int i = 0; i < N; i++) mv[i] = 0;
        end else if (iv) begin
            slot = find(ivpn);
            if (slot >= 0) mv[slot] = 0;
        end else if (fv) begin
            slot = find(fvpn);
            if (slot < 0)
                for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
            if (slot < 0) begin
                best = stamp[0]; slot = 0;
                for (int i = 1; i < N; i++) if (stamp[i] < best) begin best = stamp[i]; slot = i; end
            end
            mv[slot] = 1; mvpn[slot] = fvpn; mppn[slot] = fppn; mperm[slot] = fp;
            stamp[slot] = now;
        end else if (eh) begin
            stamp[j] = now;
        end
    endtask

    task automatic look(input int vpn, input int acc, input string tag);
        cycle(1, vpn, acc, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input int vpn, input int ppn, input bit [3:0] fp, input string tag);
        cycle(0, 0, 0, 1, vpn, ppn, fp, 0, 0, 0, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        look(5, 0, "R1");
        fill(5, 'hA5, 4'b1100, "R7");
        look(5, 0, "R2");
        look(5, 3, "R2");
        look(5, 2, "R4");
        look(5, 1, "R5");
        fill(5, 'hA6, 4'b1101, "R6");
        look(5, 1, "R6");
        for (int k = 0; k < 15; k++) fill(100 + k, 'h300 + k, 4'b1000, "R7");
        look(5, 0, "R8");
        look(100, 0, "R8");
        look(101, 2, "R4");
        fill(200, 'h777, 4'b1010, "R8");
        look(101, 0, "R8");
        look(200, 2, "R8");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 102, "R10");
        look(102, 0, "R10");
        look(103, 0, "R10");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 999, "R10");
        look(103, 0, "R10");
        fill(300, 'h123, 4'b1000, "R7");
        fill(301, 'h124, 4'b1000, "R8");
        look(300, 0, "R7");
        cycle(1, 103, 0, 1, 400, 'h9, 4'b1000, 0, 1, 104, "R11");
        look(104, 0, "R11");
        look(400, 0, "R11");
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
        look(103, 0, "R9");
        cycle(0, 0, 0, 1, 50, 'h5, 4'b1000, 1, 0, 0, "R11");
        look(50, 0, "R11");
        for (int k = 0; k < 3000; k++) begin
            int op;
            op = $urandom_range(0, 39);
            cycle($urandom_range(0, 3) != 0, $urandom_range(0, 23), $urandom_range(0, 3),
                  op >= 4 && op < 14, $urandom_range(0, 23), $urandom_range(0, 'hFFFFF),
                  4'($urandom_range(0, 15)), op == 0, op >= 1 && op < 4,
                  $urandom_range(0, 23), "R3");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule